// File: doc/BRIEF.md
# Adder-Subtractor with Sign Correction

A combinational, parameter-width unit that either adds or subtracts two operands. A mode bit chooses the operation. A second bit says whether the operands are two's-complement numbers or plain unsigned magnitudes. Subtraction uses the usual trick: every bit of the second operand is inverted and a carry of 1 is fed into the lowest stage, so a single ripple adder serves both operations.

The two number systems read the adder's carries differently. In signed mode the unit raises an overflow flag when the carry entering the top bit differs from the carry leaving it. In unsigned subtraction a missing end carry means the subtrahend was larger than the minuend. In that case the raw sum is sent through a second invert-and-increment stage. The result then carries the magnitude of the difference, and a negative flag is set. The end carry always appears on its own output. A flag that means nothing in the current mode is held at 0.

Top module: `asu_core`

## Requirements
- R1: With sub_mode=0, result equals (opa + opb) mod 2^WIDTH and cout equals bit WIDTH of the full sum, in both signed and unsigned mode.
- R2: With sub_mode=1, the adder sees the bitwise inverse of opb and a carry-in of 1. cout is 1 exactly when opa >= opb read as unsigned numbers. In signed mode, result equals (opa - opb) mod 2^WIDTH.
- R3: With sub_mode=1 and signed_mode=0 and opa >= opb (unsigned): cout=1, neg=0 and result=opa-opb.
- R4: With sub_mode=1 and signed_mode=0 and opa < opb (unsigned): cout=0, neg=1 and result=opb-opa. This magnitude is formed by inverting and incrementing the raw sum, not by comparing the operands.
- R5: With signed_mode=1 and sub_mode=0, overflow is the XOR of the carry into bit WIDTH-1 and the carry out of it. At 4 bits, 7+(-7) gives cout=1 and overflow=0, while 4+4 gives cout=0 and overflow=1.
- R6: overflow is 0 whenever signed_mode=0. neg is 0 unless sub_mode=1 and signed_mode=0.
- R7: With signed_mode=1 and sub_mode=1, overflow is 1 exactly when the true difference opa-opb lies outside [-2^(WIDTH-1), 2^(WIDTH-1)-1]. At 4 bits, -8-1 overflows and -8-(-8) does not.
- R8: At WIDTH=8, signed 0-9 gives result 8'b11110111 with overflow=0. Unsigned 0-9 gives result 9 with neg=1 and cout=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opa | input | WIDTH | First operand (minuend when subtracting) |
| opb | input | WIDTH | Second operand (subtrahend when subtracting) |
| sub_mode | input | 1 | 0 = add, 1 = subtract |
| signed_mode | input | 1 | 1 = operands are two's complement, 0 = unsigned |
| result | output | WIDTH | Sum, difference, or unsigned magnitude |
| cout | output | 1 | End carry out of the top adder stage |
| overflow | output | 1 | Two's-complement overflow, signed mode only |
| neg | output | 1 | Difference was negative, unsigned subtract only |

## Verification
The bench goes after the places where the carries are easy to misread. A carry out that is not an overflow (7+(-7)) would raise a false overflow in a design that used cout as the flag. Same-sign overflow with no carry (4+4) would be missed by the same design. The minimum negative operand in subtraction (-8-1, -8-(-8)) would trip a design that negates opb on its own instead of inverting and adding 1. Unsigned subtraction with equal operands, and with the subtrahend one larger, separates a correct end-carry test from a negation that is off by one or a neg flag with the wrong polarity. The 8-bit -9 pattern catches a one's-complement result left without its increment.

// File: rtl/asu_pkg.sv
package asu_pkg;

  typedef struct packed {
    logic subtract;
    logic is_signed;
  } asu_mode_t;

  function automatic asu_mode_t decode_mode(input logic sub, input logic sgn);
    asu_mode_t m;
    m.subtract  = sub;
    m.is_signed = sgn;
    return m;
  endfunction

  function automatic logic fa_sum(input logic x, input logic y, input logic ci);
    return x ^ y ^ ci;
  endfunction

  function automatic logic fa_carry(input logic x, input logic y, input logic ci);
    return (x & y) | (ci & (x ^ y));
  endfunction

  function automatic logic ha_sum(input logic x, input logic ci);
    return x ^ ci;
  endfunction

  function automatic logic ha_carry(input logic x, input logic ci);
    return x & ci;
  endfunction

endpackage

// File: rtl/asu_bcond.sv
module asu_bcond #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] b_in,
  input  logic             invert,
  output logic [WIDTH-1:0] b_out
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign b_out[i] = b_in[i] ^ invert;
  end

  always_comb begin
    a_r2_invert_all: assert (invert ? (b_out == ~b_in) : (b_out == b_in))
      else $error("R2: conditional inverter mismatch");
  end
endmodule

// File: rtl/asu_ripple.sv
module asu_ripple #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             cin,
  output logic [WIDTH-1:0] sum,
  output logic [WIDTH:0]   carry
);
  assign carry[0] = cin;

  for (genvar i = 0; i < WIDTH; i++) begin : g_fa
    assign sum[i]       = asu_pkg::fa_sum(a[i], b[i], carry[i]);
    assign carry[i+1]   = asu_pkg::fa_carry(a[i], b[i], carry[i]);
  end

  always_comb begin
    a_r1_ripple_total: assert ({carry[WIDTH], sum} ==
                               ({1'b0, a} + {1'b0, b} + {{WIDTH{1'b0}}, cin}))
      else $error("R1: ripple chain total mismatch");
  end
endmodule

// File: rtl/asu_negate.sv
module asu_negate #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] x,
  output logic [WIDTH-1:0] y
);
  logic [WIDTH-1:0] inv;
  logic [WIDTH-1:0] c;

  assign inv  = ~x;
  assign c[0] = 1'b1;

  for (genvar i = 0; i < WIDTH; i++) begin : g_inc
    assign y[i] = asu_pkg::ha_sum(inv[i], c[i]);
    if (i < WIDTH - 1) begin : g_chain
      assign c[i+1] = asu_pkg::ha_carry(inv[i], c[i]);
    end
  end

  always_comb begin
    a_r4_negate_inverse: assert (WIDTH'(x + y) == '0)
      else $error("R4: negation stage does not cancel its input");
  end
endmodule

// File: rtl/asu_core.sv
module asu_core #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] opa,
  input  logic [WIDTH-1:0] opb,
  input  logic             sub_mode,
  input  logic             signed_mode,
  output logic [WIDTH-1:0] result,
  output logic             cout,
  output logic             overflow,
  output logic             neg
);
  import asu_pkg::*;

  localparam int MSB = WIDTH - 1;

  asu_mode_t        mode;
  logic [WIDTH-1:0] b_eff;
  logic [WIDTH-1:0] raw_sum;
  logic [WIDTH:0]   carry;
  logic [WIDTH-1:0] magnitude;
  logic             end_carry;
  logic             carry_into_msb;
  logic             borrow_seen;

  assign mode = decode_mode(sub_mode, signed_mode);

  asu_bcond #(.WIDTH(WIDTH)) u_bcond (
    .b_in   (opb),
    .invert (mode.subtract),
    .b_out  (b_eff)
  );

  asu_ripple #(.WIDTH(WIDTH)) u_ripple (
    .a     (opa),
    .b     (b_eff),
    .cin   (mode.subtract),
    .sum   (raw_sum),
    .carry (carry)
  );

  asu_negate #(.WIDTH(WIDTH)) u_negate (
    .x (raw_sum),
    .y (magnitude)
  );

  assign end_carry      = carry[WIDTH];
  assign carry_into_msb = carry[MSB];
  assign borrow_seen    = mode.subtract & ~mode.is_signed & ~end_carry;

  assign result   = borrow_seen ? magnitude : raw_sum;
  assign cout     = end_carry;
  assign overflow = mode.is_signed & (carry_into_msb ^ end_carry);
  assign neg      = borrow_seen;

  always_comb begin
    if (sub_mode && !signed_mode && !neg) begin
      a_r3_diff_restores: assert (WIDTH'(result + opb) == opa)
        else $error("R3: positive difference does not restore minuend");
    end
    if (neg) begin
      a_r4_mag_restores: assert ((WIDTH'(opa + result) == opb) && (result != '0))
        else $error("R4: magnitude does not restore subtrahend");
    end
    if (overflow && !sub_mode) begin
      a_r5_ovf_same_sign: assert ((opa[MSB] == opb[MSB]) && (result[MSB] != opa[MSB]))
        else $error("R5: overflow without same-sign operands");
    end
    if (overflow && sub_mode) begin
      a_r7_ovf_diff_sign: assert ((opa[MSB] != opb[MSB]) && (result[MSB] != opa[MSB]))
        else $error("R7: subtract overflow without opposite-sign operands");
    end
    a_r6_flags_gated: assert (!(overflow && !signed_mode) &&
                              !(neg && (signed_mode || !sub_mode)))
      else $error("R6: flag active outside its mode");
  end
endmodule

// File: tb/asu_core_tb_top.sv
module asu_core_tb_top;
  localparam int W  = 4;
  localparam int W8 = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [W-1:0]  a_in, b_in, res;
  logic          sub_in, sgn_in, co, ovf, ng;
  logic [W8-1:0] a8, b8, res8;
  logic          sub8, sgn8, co8, ovf8, ng8;

  int total = 0;
  int bad   = 0;

  asu_core #(.WIDTH(W)) dut_i (
    .opa(a_in), .opb(b_in), .sub_mode(sub_in), .signed_mode(sgn_in),
    .result(res), .cout(co), .overflow(ovf), .neg(ng)
  );

  asu_core #(.WIDTH(W8)) dut8_i (
    .opa(a8), .opb(b8), .sub_mode(sub8), .signed_mode(sgn8),
    .result(res8), .cout(co8), .overflow(ovf8), .neg(ng8)
  );

  task automatic check(input string tag, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d (a=%0d b=%0d sub=%0b sgn=%0b)",
               tag, what, act, exp, a_in, b_in, sub_in, sgn_in);
    end
  endtask

  task automatic apply4(input int a, input int b, input logic s, input logic g);
    @(posedge clk);
    a_in = W'(a); b_in = W'(b); sub_in = s; sgn_in = g;
    @(negedge clk);
  endtask

  task automatic apply8(input int a, input int b, input logic s, input logic g);
    @(posedge clk);
    a8 = W8'(a); b8 = W8'(b); sub8 = s; sgn8 = g;
    @(negedge clk);
  endtask

  function automatic int as_signed4(input int v);
    return (v >= 8) ? v - 16 : v;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    a_in = '0; b_in = '0; sub_in = 1'b0; sgn_in = 1'b0;
    a8 = '0; b8 = '0; sub8 = 1'b0; sgn8 = 1'b0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // idle state after reset: zero operands in add mode (R1)
    check("R1", "idle result", int'(res), 0);
    check("R1", "idle cout", int'(co), 0);
    check("R6", "idle overflow", int'(ovf), 0);
    check("R6", "idle neg", int'(ng), 0);

    // exhaustive sweep over 4-bit operands in all four modes
    for (int g = 0; g < 2; g++) begin
      for (int s = 0; s < 2; s++) begin
        for (int a = 0; a < 16; a++) begin
          for (int b = 0; b < 16; b++) begin
            int e_res, e_co, e_ovf, e_neg, sd;
            string t_res, t_co, t_ovf, t_neg;
            apply4(a, b, s[0], g[0]);
            e_ovf = 0; e_neg = 0;
            if (s == 0) begin
              e_res = (a + b) % 16;
              e_co  = (a + b >= 16) ? 1 : 0;
              t_res = "R1"; t_co = "R1";
              if (g == 1) begin
                sd = as_signed4(a) + as_signed4(b);
                e_ovf = (sd > 7 || sd < -8) ? 1 : 0;
              end
              t_ovf = (g == 1) ? "R5" : "R6";
              t_neg = "R6";
            end else begin
              e_co = (a >= b) ? 1 : 0;
              t_co = "R2";
              if (g == 1) begin
                e_res = (a - b + 16) % 16;
                sd = as_signed4(a) - as_signed4(b);
                e_ovf = (sd > 7 || sd < -8) ? 1 : 0;
                t_res = "R2"; t_ovf = "R7"; t_neg = "R6";
              end else begin
                e_neg = (a < b) ? 1 : 0;
                e_res = (a >= b) ? a - b : b - a;
                t_res = (a < b) ? "R4" : "R3";
                t_neg = t_res;
                t_ovf = "R6";
              end
            end
            check(t_res, "result", int'(res), e_res);
            check(t_co, "cout", int'(co), e_co);
            check(t_ovf, "overflow", int'(ovf), e_ovf);
            check(t_neg, "neg", int'(ng), e_neg);
          end
        end
      end
    end

    // R5 named corners: 7 + (-7) carries without overflow; 4 + 4 overflows without carry
    apply4(7, 9, 1'b0, 1'b1);
    check("R5", "7+(-7) cout", int'(co), 1);
    check("R5", "7+(-7) overflow", int'(ovf), 0);
    apply4(4, 4, 1'b0, 1'b1);
    check("R5", "4+4 cout", int'(co), 0);
    check("R5", "4+4 overflow", int'(ovf), 1);
    // R7: -8-1 overflows, -8-(-8) does not
    apply4(8, 1, 1'b1, 1'b1);
    check("R7", "-8-1 overflow", int'(ovf), 1);
    apply4(8, 8, 1'b1, 1'b1);
    check("R7", "-8-(-8) overflow", int'(ovf), 0);
    // R4 boundary: subtrahend one larger
    apply4(5, 6, 1'b1, 1'b0);
    check("R4", "5-6 magnitude", int'(res), 1);
    check("R4", "5-6 neg", int'(ng), 1);

    // R8 at 8 bits
    apply8(0, 9, 1'b1, 1'b1);
    check("R8", "signed 0-9 pattern", int'(res8), 8'b11110111);
    check("R8", "signed 0-9 overflow", int'(ovf8), 0);
    apply8(0, 9, 1'b1, 1'b0);
    check("R8", "unsigned 0-9 magnitude", int'(res8), 9);
    check("R8", "unsigned 0-9 neg", int'(ng8), 1);
    check("R8", "unsigned 0-9 cout", int'(co8), 0);
    apply8(200, 100, 1'b1, 1'b0);
    check("R3", "unsigned 200-100", int'(res8), 100);
    check("R3", "unsigned 200-100 neg", int'(ng8), 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule